// File: doc/BRIEF.md
# Task Priority Interrupt Gate

This block filters external interrupt requests against a single numeric task-priority threshold. Each of up to fifteen request lines has a fixed priority class between 1 and 15, wired in through a static class bus. A pulse on a line's request input marks that line pending. Every cycle the gate picks the pending line with the highest class. If that class is strictly above the threshold, the gate presents it on a registered deliver output, together with its class and line index.

Software loads the threshold through a small write port. Only four threshold bits exist, so the gate ignores a write that sets any bit above those four. A threshold of zero passes every class. A threshold of fifteen blocks every class. The consumer acknowledges a delivered interrupt with a single pulse, which clears that line's pending bit. If the threshold is lowered, any pending request that was held back becomes deliverable, and its line does not have to request again.

Top module: `prio_irq_gate`

## Requirements
- R1: Classes run from 1 (lowest) to 15 (highest). A line whose configured class is 0 is never delivered, even when it is pending.
- R2: A pending line of class c is delivered only when c is strictly greater than the threshold. For example, threshold 9 holds back classes 1 to 9 and lets classes 10 to 15 through.
- R3: With threshold 0, every pending line of class 1 to 15 is deliverable.
- R4: With threshold 15, `deliverValid` stays low whatever is pending.
- R5: Reset clears the threshold to 0 and all pending bits, and `deliverValid` reads 0.
- R6: A write whose data has any of bits [7:4] set leaves the threshold unchanged. Any other write loads data bits [3:0], and `thrValue` shows the new value one cycle after the write edge.
- R7: When several eligible lines are pending, the highest class is delivered. Between equal classes, the lowest line index wins.
- R8: `ackIn` while `deliverValid` is high clears the pending bit of the line in `deliverLine`, and that line is not presented on the next cycle. `ackIn` while `deliverValid` is low has no effect. A request on the acknowledged line in the same cycle leaves that line pending.
- R9: Lowering the threshold below a pending line's class delivers that line one cycle after the threshold register changes, with no new request.
- R10: A request sampled at a clock edge shows up on the deliver outputs at the following edge (one cycle of registered latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineClass | input | NUM_LINES*4 | Static class of each line; line i uses bits [4i+3:4i] |
| reqSet | input | NUM_LINES | One pulse per line sets that line's pending bit |
| thrWrEn | input | 1 | Threshold write strobe |
| thrWrData | input | DATA_W | Threshold write data; bits above [3:0] must be zero |
| ackIn | input | 1 | Acknowledge of the delivered interrupt |
| thrValue | output | 4 | Current threshold |
| deliverValid | output | 1 | An interrupt is being presented |
| deliverClass | output | 4 | Class of the presented interrupt |
| deliverLine | output | LINE_W | Index of the presented line |

## Verification
An acknowledge can arrive in the same cycle as a fresh request on the acknowledged line. It can also arrive together with a threshold write that blocks or releases other lines. The bench provokes both collisions in directed steps, and again in a pseudo-random run where requests, acknowledges and writes overlap freely. Each cycle the bench judges the deliver outputs against its own arithmetic model. In that model the acknowledged bit is cleared before the new request is merged in, and the winner is picked from the threshold that held before the write.

// File: rtl/prio_irq_gate_pkg.sv
package prio_irq_gate_pkg;
  localparam int CLASS_W = 4;

  typedef struct packed {
    logic thrLoad;   // accepted threshold write
    logic ackClr;    // acknowledge of a presented interrupt
    logic winValid;  // an eligible winner exists this cycle
  } gateStrobes_t;
endpackage

// File: rtl/prio_irq_gate_ctrl.sv
module prio_irq_gate_ctrl
  import prio_irq_gate_pkg::*;
#(
  parameter int NUM_LINES = 15,
  parameter int DATA_W    = 8,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES*CLASS_W-1:0] lineClass,
  input  logic [NUM_LINES-1:0]         pending,
  input  logic [CLASS_W-1:0]           thrQ,
  input  logic                         thrWrEn,
  input  logic [DATA_W-1:CLASS_W]      thrWrHigh,
  input  logic                         ackIn,
  input  logic                         dlvValidQ,
  input  logic [LINE_W-1:0]            dlvLineQ,
  output gateStrobes_t                 strobes,
  output logic [NUM_LINES-1:0]         clrMask,
  output logic [LINE_W-1:0]            winLine,
  output logic [CLASS_W-1:0]           winClass
);
  logic [NUM_LINES-1:0] effPend;
  logic                 bestValid;
  logic                 ackHit;

  assign ackHit = ackIn && dlvValidQ;

  // one-hot clear of the line being acknowledged
  always_comb begin
    clrMask = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (ackHit && (dlvLineQ == LINE_W'(i))) clrMask[i] = 1'b1;
    end
  end

  // the acknowledged line must not win again in the same cycle
  assign effPend = pending & ~clrMask;

  // highest class above threshold; strict compare keeps the lowest index on ties
  always_comb begin
    bestValid = 1'b0;
    winClass  = '0;
    winLine   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (effPend[i] && (lineClass[i*CLASS_W +: CLASS_W] > thrQ) &&
          (!bestValid || (lineClass[i*CLASS_W +: CLASS_W] > winClass))) begin
        bestValid = 1'b1;
        winClass  = lineClass[i*CLASS_W +: CLASS_W];
        winLine   = LINE_W'(i);
      end
    end
  end

  assign strobes.thrLoad  = thrWrEn && (thrWrHigh == '0);
  assign strobes.ackClr   = ackHit;
  assign strobes.winValid = bestValid;
endmodule

// File: rtl/prio_irq_gate_dpath.sv
module prio_irq_gate_dpath
  import prio_irq_gate_pkg::*;
#(
  parameter int NUM_LINES = 15,
  parameter int DATA_W    = 8,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gateStrobes_t         strobes,
  input  logic [NUM_LINES-1:0] reqSet,
  input  logic [NUM_LINES-1:0] clrMask,
  input  logic [CLASS_W-1:0]   thrWrLow,
  input  logic [LINE_W-1:0]    winLine,
  input  logic [CLASS_W-1:0]   winClass,
  output logic [NUM_LINES-1:0] pendingQ,
  output logic [CLASS_W-1:0]   thrQ,
  output logic                 dlvValidQ,
  output logic [CLASS_W-1:0]   dlvClassQ,
  output logic [LINE_W-1:0]    dlvLineQ
);
  // a request in the acknowledge cycle survives the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingQ <= '0;
    else       pendingQ <= (pendingQ & ~clrMask) | reqSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                thrQ <= '0;
    else if (strobes.thrLoad) thrQ <= thrWrLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlvValidQ <= 1'b0;
      dlvClassQ <= '0;
      dlvLineQ  <= '0;
    end else begin
      dlvValidQ <= strobes.winValid;
      dlvClassQ <= strobes.winValid ? winClass : '0;
      dlvLineQ  <= strobes.winValid ? winLine  : '0;
    end
  end

  logic unusedAck;
  assign unusedAck = strobes.ackClr;
endmodule

// File: rtl/prio_irq_gate.sv
module prio_irq_gate
  import prio_irq_gate_pkg::*;
#(
  parameter int NUM_LINES = 15,
  parameter int DATA_W    = 8,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_LINES*CLASS_W-1:0] lineClass,
  input  logic [NUM_LINES-1:0]         reqSet,
  input  logic                         thrWrEn,
  input  logic [DATA_W-1:0]            thrWrData,
  input  logic                         ackIn,
  output logic [CLASS_W-1:0]           thrValue,
  output logic                         deliverValid,
  output logic [CLASS_W-1:0]           deliverClass,
  output logic [LINE_W-1:0]            deliverLine
);
  gateStrobes_t         strobes;
  logic [NUM_LINES-1:0] pendingQ;
  logic [NUM_LINES-1:0] clrMask;
  logic [LINE_W-1:0]    winLine;
  logic [CLASS_W-1:0]   winClass;

  prio_irq_gate_ctrl #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) ctrl (
    .lineClass (lineClass),
    .pending   (pendingQ),
    .thrQ      (thrValue),
    .thrWrEn   (thrWrEn),
    .thrWrHigh (thrWrData[DATA_W-1:CLASS_W]),
    .ackIn     (ackIn),
    .dlvValidQ (deliverValid),
    .dlvLineQ  (deliverLine),
    .strobes   (strobes),
    .clrMask   (clrMask),
    .winLine   (winLine),
    .winClass  (winClass)
  );

  prio_irq_gate_dpath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqSet    (reqSet),
    .clrMask   (clrMask),
    .thrWrLow  (thrWrData[CLASS_W-1:0]),
    .winLine   (winLine),
    .winClass  (winClass),
    .pendingQ  (pendingQ),
    .thrQ      (thrValue),
    .dlvValidQ (deliverValid),
    .dlvClassQ (deliverClass),
    .dlvLineQ  (deliverLine)
  );
endmodule

// File: rtl/prio_irq_gate_chk.sv
module prio_irq_gate_chk #(
  parameter int DATA_W = 8,
  parameter int LINE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              thrWrEn,
  input logic [DATA_W-1:0] thrWrData,
  input logic [3:0]        thrValue,
  input logic              deliverValid,
  input logic [3:0]        deliverClass,
  input logic              ackIn,
  input logic [LINE_W-1:0] deliverLine
);
  // a presented class is always above the threshold it was chosen against
  assert_above_thr_R2: assert property (@(posedge clk) disable iff (!rstN)
    deliverValid |-> (deliverClass > $past(thrValue)));

  // a full threshold lets nothing through
  assert_block_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(thrValue) == 4'd15) |-> !deliverValid);

  // class zero is never presented
  assert_class_nonzero_R1: assert property (@(posedge clk) disable iff (!rstN)
    deliverValid |-> (deliverClass != 4'd0));

  // oversized writes are dropped
  assert_reject_wide_R6: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrEn && (thrWrData[DATA_W-1:4] != '0)) |=> $stable(thrValue));

  // clean writes land in the threshold
  assert_load_thr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrEn && (thrWrData[DATA_W-1:4] == '0)) |=> (thrValue == $past(thrWrData[3:0])));

  // an acknowledged line is not presented again in the following cycle
  assert_ack_moves_on_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && deliverValid) |=> (!deliverValid || (deliverLine != $past(deliverLine))
                                 || $past(ackIn && deliverValid && 1'b0)));
endmodule

bind prio_irq_gate prio_irq_gate_chk #(.DATA_W(DATA_W), .LINE_W(LINE_W)) chk (
  .clk          (clk),
  .rstN         (rstN),
  .thrWrEn      (thrWrEn),
  .thrWrData    (thrWrData),
  .thrValue     (thrValue),
  .deliverValid (deliverValid),
  .deliverClass (deliverClass),
  .ackIn        (ackIn),
  .deliverLine  (deliverLine)
);

// File: tb/prio_irq_gate_test.sv
module prio_irq_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 15;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL*4-1:0] lineClass;
  logic [NL-1:0] reqSet = '0;
  logic          thrWrEn = 1'b0;
  logic [7:0]    thrWrData = '0;
  logic          ackIn = 1'b0;
  logic [3:0]    thrValue;
  logic          deliverValid;
  logic [3:0]    deliverClass;
  logic [LW-1:0] deliverLine;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  // bench model state
  logic [NL-1:0] mPend = '0;
  logic [3:0]    mThr = '0;
  logic          eValid = 1'b0;
  logic [3:0]    eClass = '0;
  logic [LW-1:0] eLine = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_gate #(.NUM_LINES(NL), .DATA_W(8)) uut (
    .clk(clk), .rstN(rstN), .lineClass(lineClass), .reqSet(reqSet),
    .thrWrEn(thrWrEn), .thrWrData(thrWrData), .ackIn(ackIn),
    .thrValue(thrValue), .deliverValid(deliverValid),
    .deliverClass(deliverClass), .deliverLine(deliverLine)
  );

  // line 0 has class 0 (R1); line 14 shares class 11 with line 1 (R7 tie)
  function automatic logic [3:0] clsOf(int i);
    if (i == 14) return 4'd11;
    return 4'((i * 11) % 16);
  endfunction

  initial begin
    for (int i = 0; i < NL; i++) lineClass[i*4 +: 4] = clsOf(i);
  end

  task automatic compare(string tag);
    nVec++;
    if (deliverValid !== eValid || thrValue !== mThr ||
        (eValid && (deliverClass !== eClass || deliverLine !== eLine))) begin
      nBad++;
      $display("FAIL %s: got v=%0b c=%0d l=%0d thr=%0d, expected v=%0b c=%0d l=%0d thr=%0d",
               tag, deliverValid, deliverClass, deliverLine, thrValue,
               eValid, eClass, eLine, mThr);
    end
  endtask

  task automatic step(input logic [NL-1:0] req, input bit wr, input logic [7:0] wd,
                      input bit ack, input string tag);
    logic [NL-1:0] clr;
    logic [NL-1:0] eff;
    logic          nv;
    logic [3:0]    nc;
    logic [LW-1:0] nl;
    @(negedge clk);
    reqSet = req; thrWrEn = wr; thrWrData = wd; ackIn = ack;
    clr = '0;
    if (ack && eValid) clr[eLine] = 1'b1;
    eff = mPend & ~clr;
    nv = 1'b0; nc = '0; nl = '0;
    for (int c = 15; c >= 1; c--) begin
      for (int i = NL - 1; i >= 0; i--) begin
        if (eff[i] && clsOf(i) == 4'(c) && 4'(c) > mThr && (!nv || nc == 4'(c))) begin
          nv = 1'b1; nc = 4'(c); nl = LW'(i);
        end
      end
    end
    mPend = eff | req;
    if (wr && wd[7:4] == 4'd0) mThr = wd[3:0];
    eValid = nv; eClass = nc; eLine = nl;
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic drain(string tag);
    for (int k = 0; k < 20; k++) step('0, 0, '0, 1, tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    string tg;
    // R5: reset state
    repeat (3) @(posedge clk);
    #1; compare("R5 in reset");
    @(negedge clk); rstN = 1'b1;
    step('0, 0, '0, 0, "R5 after reset");

    // R2 R3 R4 R10: every threshold against every single line
    for (int t = 0; t < 16; t++) begin
      tg = (t == 0) ? "R3" : (t == 15) ? "R4" : "R2";
      step('0, 1, 8'(t), 0, "R6 load");
      for (int ln = 0; ln < NL; ln++) begin
        step(NL'(1) << ln, 0, '0, 0, "R10 latency");
        step('0, 0, '0, 0, tg);
        step('0, 0, '0, 1, "R8 ack");
        step('0, 0, '0, 0, "R1 R8 cleared");
        step('0, 1, 8'd0, 0, "R9 release");
        drain("R8 drain");
        step('0, 1, 8'(t), 0, "R6 reload");
      end
    end

    // R6: rejected writes
    step('0, 1, 8'h07, 0, "R6 load");
    step('0, 1, 8'h3A, 0, "R6 reject");
    step('0, 1, 8'h80, 0, "R6 reject");
    step('0, 0, '0, 0, "R6 kept");

    // R7: everything pending, drain in priority order with tie
    step('0, 1, 8'd0, 0, "R6 load");
    step({NL{1'b1}}, 0, '0, 0, "R7 all");
    for (int k = 0; k < NL + 2; k++) step('0, 0, '0, 1, "R7 order");

    // R9: pending held back by 15, released by lowering
    step('0, 1, 8'd15, 0, "R6 load");
    step({NL{1'b1}}, 0, '0, 0, "R4 hold");
    step('0, 0, '0, 1, "R4 hold ack ignored");
    step('0, 1, 8'd12, 0, "R9 lower");
    step('0, 0, '0, 0, "R9 delivered");
    step('0, 0, '0, 0, "R9 delivered");
    step('0, 1, 8'd0, 0, "R9 lower");
    drain("R9 drain");

    // R8: ack collides with request on same line; ack with nothing shown
    step(NL'(1) << 3, 0, '0, 0, "R8 set");
    step('0, 0, '0, 0, "R8 shown");
    step(NL'(1) << 3, 0, '0, 1, "R8 ack+req");
    step('0, 0, '0, 0, "R8 still pending");
    step('0, 0, '0, 1, "R8 ack");
    step('0, 0, '0, 1, "R8 ack idle");
    step('0, 0, '0, 0, "R8 idle");

    // R7 R8 R9: pseudo-random overlap of requests, acks and writes
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      logic [NL-1:0] rq;
      logic          w;
      logic [7:0]    d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rq = (lfsr[2:0] == 3'd0) ? (NL'(1) << (lfsr[7:4] % NL)) : '0;
      w  = (lfsr[11:9] == 3'd5);
      d  = (lfsr[15:14] == 2'd3) ? {4'h2, lfsr[3:0]} : {4'h0, lfsr[12:9]};
      step(rq, w, d, lfsr[8], "R7 R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule